// File: doc/BRIEF.md
# Banked External Memory Decoder

This block sits between an 8-bit CPU's 16-bit address bus and the memory system of a small controller. It turns each bus cycle into an active-low enable for one of two external memory chips, or into a select and bank index for a small internal banked ROM. It also drives a seven-bit bank bus that widens the CPU's 16 KiB windows into larger external address spaces.

Three address windows are remapped: 4000h–7FFFh, 8000h–BFFFh and C000h–FFFFh. Which memory answers, and which bank number appears on the bank pins, depends on two bank registers, a two-bit mapping control field and a board pin that turns the internal ROM off. Two of the control combinations are not allowed. The block flags them and then keeps every memory deselected. A sleep input forces both external enables high. All outputs are combinational in the bus inputs and in the registered configuration.

Top module: `xmem_bank_decoder`

## Requirements
- R1: Reset clears bank register A (5 bits), bank register B (7 bits) and the mapping field (2 bits). A write with `cfg_we`=1 loads the register chosen by `cfg_sel`: 0 loads A from `cfg_wdata[4:0]`, 1 loads B from `cfg_wdata[6:0]`, 2 loads the mapping field from `cfg_wdata[1:0]` (bit 0 = window lock, bit 1 = middle window source), and 3 loads nothing. The new value governs decoding from the cycle after the write edge.
- R2: With the lock bit at 0, an access (`cpu_req`=1) to 4000h–7FFFh drives `xce1_n` low, and `bank_pins[4:0]` shows register A.
- R3: With the lock bit at 1 in a legal configuration, an access to 4000h–7FFFh leaves `xce1_n` high.
- R4: `cfg_bad` is 1 when the lock bit is 1 and either `rom_int_off`=1 or the source bit is 0. While `cfg_bad` is 1, no chip enable and no internal ROM select is asserted in any window.
- R5: With the source bit at 0, an access to 8000h–BFFFh drives `xce2_n` low, and `bank_pins[6:0]` shows register B, for either value of `rom_int_off`.
- R6: With the source bit at 1 and `rom_int_off`=1, an access to 8000h–BFFFh drives `xce2_n` low, and `bank_pins[4:0]` shows register A.
- R7: With the source bit at 1 and `rom_int_off`=0, a read of 8000h–BFFFh with register A in 1Ch–1Fh keeps `xce2_n` high, raises `irom_sel`, and sets `irom_bank` to A−1Ch.
- R8: In the case of R7 with register A below 1Ch, `irom_miss` is 1 and `irom_sel` stays 0.
- R9: An access to C000h–FFFFh with `rom_int_off`=1 drives `xce2_n` low with `bank_pins[4:0]`=1Fh. With `rom_int_off`=0, a read raises `irom_sel` with `irom_bank`=3, and `xce2_n` stays high.
- R10: A write cycle (`cpu_wr`=1) never raises `irom_sel`, and `irom_bank` then reads 0.
- R11: Whenever `xce2_n` is high, `bank_pins[4:0]` shows register A. `bank_pins[6:5]` always show register B bits 6–5.
- R12: While `sleep_mode`=1, `xce1_n` and `xce2_n` are both high.
- R13: With `cpu_req`=0, or with an address below 4000h, no chip enable, `irom_sel` or `irom_miss` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_req | input | 1 | A bus cycle is in progress |
| cpu_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| rom_int_off | input | 1 | Board strap: 1 disables the internal ROM |
| sleep_mode | input | 1 | Chip is asleep; external enables are forced high |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0 bank A, 1 bank B, 2 mapping field |
| cfg_wdata | input | 7 | Configuration write data |
| xce1_n | output | 1 | External chip 1 enable, active low |
| xce2_n | output | 1 | External chip 2 enable, active low |
| bank_pins | output | 7 | Bank number bus; bits 6–5 are general-purpose outputs |
| irom_sel | output | 1 | Internal ROM read select |
| irom_bank | output | 2 | Internal ROM bank index |
| cfg_bad | output | 1 | Prohibited mapping configuration |
| irom_miss | output | 1 | Internal window hit with no internal bank present |

## Verification
The enables, bank pins, ROM select, index and miss flag are combinational, so each is due in the same cycle as the address and strobes that cause it. A configuration write changes them one cycle later, after the register edge. The bench therefore drives inputs just after a rising edge, updates its own register model on the rising edge, and compares every output at the following falling edge. Each cycle's expectation is worked out from the model's registers as they stand after that edge.

// File: rtl/xbd_pkg.sv
package xbd_pkg;

  // address window of the current bus cycle, ordered by address
  typedef enum logic [1:0] {
    WIN_BOOT = 2'd0,  // lowest quarter: not remapped
    WIN_CE1  = 2'd1,  // external chip 1 window
    WIN_MID  = 2'd2,  // external chip 2 or internal ROM, banked
    WIN_TOP  = 2'd3   // program window, fixed bank
  } xbd_win_e;

  // configuration register selects
  localparam logic [1:0] SEL_BANK_A = 2'd0;
  localparam logic [1:0] SEL_BANK_B = 2'd1;
  localparam logic [1:0] SEL_MAP    = 2'd2;

  // mapping field contents
  typedef struct packed {
    logic src_int;  // middle window source bit
    logic lock;     // chip 1 window lock bit
  } xbd_map_t;

  // the combinations the mapping field must never hold
  function automatic logic map_illegal(input xbd_map_t m, input logic rom_off);
    return m.lock & (rom_off | ~m.src_int);
  endfunction

endpackage

// File: rtl/xbd_regs.sv
module xbd_regs
  import xbd_pkg::*;
#(
  parameter int BANK_W = 5,
  parameter int GPO_W  = 2,
  localparam int REG_W = BANK_W + GPO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [REG_W-1:0]  wdata,
  output logic [BANK_W-1:0] bank_a,
  output logic [REG_W-1:0]  bank_b,
  output xbd_map_t          map_q
);

  logic wr_a, wr_b, wr_map;
  assign wr_a   = we && (sel == SEL_BANK_A);
  assign wr_b   = we && (sel == SEL_BANK_B);
  assign wr_map = we && (sel == SEL_MAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_a <= '0;
      bank_b <= '0;
      map_q  <= '0;
    end else begin
      if (wr_a)   bank_a <= wdata[BANK_W-1:0];
      if (wr_b)   bank_b <= wdata;
      if (wr_map) map_q  <= xbd_map_t'(wdata[1:0]);
    end
  end

  // R1
  bank_a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a |=> (bank_a == $past(wdata[BANK_W-1:0])));

  // R1
  map_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_map |=> (map_q == $past(wdata[1:0])));

  // R1
  sel3_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == 2'd3) |=> ($stable(bank_a) && $stable(bank_b) && $stable(map_q)));

endmodule

// File: rtl/xbd_window.sv
module xbd_window
  import xbd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output xbd_win_e          win
);

  localparam int unsigned QUARTER = 1 << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] LIM_CE1 = ADDR_W'(QUARTER);
  localparam logic [ADDR_W-1:0] LIM_MID = ADDR_W'(2 * QUARTER);
  localparam logic [ADDR_W-1:0] LIM_TOP = ADDR_W'(3 * QUARTER);

  always_comb begin
    if (addr < LIM_CE1)      win = WIN_BOOT;
    else if (addr < LIM_MID) win = WIN_CE1;
    else if (addr < LIM_TOP) win = WIN_MID;
    else                     win = WIN_TOP;
  end

endmodule

// File: rtl/xbd_route.sv
module xbd_route
  import xbd_pkg::*;
#(
  parameter int BANK_W     = 5,
  parameter int GPO_W      = 2,
  parameter int IROM_BANKS = 4,
  localparam int REG_W     = BANK_W + GPO_W,
  localparam int IDX_W     = $clog2(IROM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xbd_win_e          win,
  input  logic              req,
  input  logic              wr,
  input  logic              sleep,
  input  logic              rom_off,
  input  logic [BANK_W-1:0] bank_a,
  input  logic [REG_W-1:0]  bank_b,
  input  xbd_map_t          map_q,
  output logic              ce1_n,
  output logic              ce2_n,
  output logic [REG_W-1:0]  bank_pins,
  output logic              irom_sel,
  output logic [IDX_W-1:0]  irom_bank,
  output logic              cfg_bad,
  output logic              irom_miss
);

  // internal ROM occupies the highest IROM_BANKS bank numbers
  function automatic logic irom_present(input logic [BANK_W-1:0] b);
    return &b[BANK_W-1:IDX_W];
  endfunction

  // named internal events, used by the logic and the assertions
  logic cfg_illegal, go;
  logic ce1_hit, mid_ext, mid_int, top_ext, top_int;
  logic ext2_cycle, int_read_mid, int_read_top;
  logic [BANK_W-1:0] low_bank;

  assign cfg_illegal = map_illegal(map_q, rom_off);
  assign go          = req & ~cfg_illegal;

  assign ce1_hit = go & (win == WIN_CE1) & ~map_q.lock;
  assign mid_ext = go & (win == WIN_MID) & (~map_q.src_int | rom_off);
  assign mid_int = go & (win == WIN_MID) & map_q.src_int & ~rom_off;
  assign top_ext = go & (win == WIN_TOP) & rom_off;
  assign top_int = go & (win == WIN_TOP) & ~rom_off;

  assign ext2_cycle   = (mid_ext | top_ext) & ~sleep;
  assign int_read_mid = mid_int & ~wr & irom_present(bank_a);
  assign int_read_top = top_int & ~wr;

  assign ce1_n = ~(ce1_hit & ~sleep);
  assign ce2_n = ~ext2_cycle;

  // bank number shown on the low pins
  always_comb begin
    low_bank = bank_a;
    if (ext2_cycle) begin
      if (top_ext)              low_bank = '1;
      else if (!map_q.src_int)  low_bank = bank_b[BANK_W-1:0];
      else                      low_bank = bank_a;
    end
  end

  generate
    if (GPO_W > 0) begin : g_gpo
      assign bank_pins = {bank_b[REG_W-1:BANK_W], low_bank};
    end else begin : g_nogpo
      assign bank_pins = low_bank;
    end
  endgenerate

  assign irom_sel = int_read_mid | int_read_top;
  always_comb begin
    if (int_read_mid)      irom_bank = bank_a[IDX_W-1:0];
    else if (int_read_top) irom_bank = '1;
    else                   irom_bank = '0;
  end

  assign cfg_bad   = cfg_illegal;
  assign irom_miss = mid_int & ~irom_present(bank_a);

  // R12
  sleep_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (ce1_n && ce2_n));

  // R4
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |-> (ce1_n && ce2_n && !irom_sel));

  // R7
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~ce1_n, ~ce2_n, irom_sel}) <= 1);

  // R10
  irom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !irom_sel);

  // R8
  miss_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irom_miss |-> !irom_sel);

  // R2
  ce1_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce1_n |-> (win == WIN_CE1));

  // R11
  idle_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce2_n |-> (bank_pins[BANK_W-1:0] == bank_a));

  // R13
  no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req || win == WIN_BOOT) |-> (ce1_n && ce2_n && !irom_sel && !irom_miss));

endmodule

// File: rtl/xmem_bank_decoder.sv
module xmem_bank_decoder
  import xbd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BANK_W     = 5,
  parameter int GPO_W      = 2,
  parameter int IROM_BANKS = 4,
  localparam int REG_W     = BANK_W + GPO_W,
  localparam int IDX_W     = $clog2(IROM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic              rom_int_off,
  input  logic              sleep_mode,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic              xce1_n,
  output logic              xce2_n,
  output logic [REG_W-1:0]  bank_pins,
  output logic              irom_sel,
  output logic [IDX_W-1:0]  irom_bank,
  output logic              cfg_bad,
  output logic              irom_miss
);

  logic [BANK_W-1:0] bank_a;
  logic [REG_W-1:0]  bank_b;
  xbd_map_t          map_q;
  xbd_win_e          win;

  xbd_regs #(.BANK_W(BANK_W), .GPO_W(GPO_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .bank_a (bank_a),
    .bank_b (bank_b),
    .map_q  (map_q)
  );

  xbd_window #(.ADDR_W(ADDR_W)) u_window (
    .addr (cpu_addr),
    .win  (win)
  );

  xbd_route #(.BANK_W(BANK_W), .GPO_W(GPO_W), .IROM_BANKS(IROM_BANKS)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .win       (win),
    .req       (cpu_req),
    .wr        (cpu_wr),
    .sleep     (sleep_mode),
    .rom_off   (rom_int_off),
    .bank_a    (bank_a),
    .bank_b    (bank_b),
    .map_q     (map_q),
    .ce1_n     (xce1_n),
    .ce2_n     (xce2_n),
    .bank_pins (bank_pins),
    .irom_sel  (irom_sel),
    .irom_bank (irom_bank),
    .cfg_bad   (cfg_bad),
    .irom_miss (irom_miss)
  );

endmodule

// File: tb/xmem_bank_decoder_bench.sv
`timescale 1ns/1ps
module xmem_bank_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_req = 1'b0, cpu_wr = 1'b0, rom_int_off = 1'b0, sleep_mode = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [6:0]  cfg_wdata = '0;
  logic        xce1_n, xce2_n, irom_sel, cfg_bad, irom_miss;
  logic [6:0]  bank_pins;
  logic [1:0]  irom_bank;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xmem_bank_decoder u_xmem_bank_decoder (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_req(cpu_req),
    .cpu_wr(cpu_wr), .rom_int_off(rom_int_off), .sleep_mode(sleep_mode),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .xce1_n(xce1_n), .xce2_n(xce2_n), .bank_pins(bank_pins),
    .irom_sel(irom_sel), .irom_bank(irom_bank), .cfg_bad(cfg_bad),
    .irom_miss(irom_miss)
  );

  // reference register model (R1)
  int mA = 0, mB = 0, mM = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mA = 0; mB = 0; mM = 0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: mA = cfg_wdata % 32;
        2'd1: mB = cfg_wdata;
        2'd2: mM = cfg_wdata % 4;
        default: ;
      endcase
    end
  end

  // behavioural expectation, compared on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int a, e_low, e_ib;
      bit lock, srci, off, legal, e_ce1, e_ce2, e_sel, e_miss;
      string tag, btag;
      a = cpu_addr; off = rom_int_off;
      lock = (mM % 2) == 1; srci = (mM / 2) == 1;
      legal = !(lock && (off || !srci));
      e_ce1 = 1; e_ce2 = 1; e_sel = 0; e_miss = 0; e_ib = 0; e_low = mA;
      tag = "R13";
      if (cpu_req && a >= 'h4000 && !legal) tag = "R4";
      else if (cpu_req && a >= 'h4000) begin
        if (a < 'h8000) begin
          tag = lock ? "R3" : (sleep_mode ? "R12" : "R2");
          if (!lock && !sleep_mode) e_ce1 = 0;
        end else if (a < 'hC000) begin
          if (!srci || off) begin
            tag = sleep_mode ? "R12" : (!srci ? "R5" : "R6");
            if (!sleep_mode) begin e_ce2 = 0; e_low = srci ? mA : mB % 32; end
          end else if (mA >= 28) begin
            tag = cpu_wr ? "R10" : "R7";
            if (!cpu_wr) begin e_sel = 1; e_ib = mA - 28; end
          end else begin
            tag = "R8"; e_miss = 1;
          end
        end else begin
          if (off) begin
            tag = sleep_mode ? "R12" : "R9";
            if (!sleep_mode) begin e_ce2 = 0; e_low = 31; end
          end else begin
            tag = cpu_wr ? "R10" : "R9";
            if (!cpu_wr) begin e_sel = 1; e_ib = 3; end
          end
        end
      end
      checks++;
      if (xce1_n !== e_ce1 || xce2_n !== e_ce2 || irom_sel !== e_sel ||
          irom_bank !== 2'(e_ib) || irom_miss !== e_miss || cfg_bad !== !legal) begin
        failures++;
        $display("FAIL %s addr=%h act ce1=%b ce2=%b sel=%b ib=%0d miss=%b bad=%b exp ce1=%b ce2=%b sel=%b ib=%0d miss=%b bad=%b",
                 tag, cpu_addr, xce1_n, xce2_n, irom_sel, irom_bank, irom_miss, cfg_bad,
                 e_ce1, e_ce2, e_sel, e_ib, e_miss, !legal);
      end
      btag = e_ce2 ? "R11" : tag;
      checks++;
      if (bank_pins !== 7'(((mB / 32) * 32) + e_low)) begin
        failures++;
        $display("FAIL %s addr=%h bank_pins act=%h exp=%h", btag, cpu_addr,
                 bank_pins, 7'(((mB / 32) * 32) + e_low));
      end
    end
  end

  task automatic cfg_write(input logic [1:0] s, input logic [6:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic bus(input logic [15:0] a, input logic r, input logic w, input logic s);
    cpu_addr = a; cpu_req = r; cpu_wr = w; sleep_mode = s;
    @(posedge clk); #1;
  endtask

  initial begin
    logic [15:0] addrs [7];
    logic [4:0]  avals [4];
    logic [6:0]  bvals [2];
    addrs = '{16'h1234, 16'h4000, 16'h7FFF, 16'h8000, 16'hBFFF, 16'hC000, 16'hFFFF};
    avals = '{5'h1C, 5'h1F, 5'h05, 5'h1D};
    bvals = '{7'h7A, 7'h25};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state, idle bus
    @(negedge clk);
    checks++;
    if (xce1_n !== 1 || xce2_n !== 1 || bank_pins !== 0 || cfg_bad !== 0 ||
        irom_sel !== 0 || irom_miss !== 0) begin
      failures++;
      $display("FAIL R1 reset act ce1=%b ce2=%b bank=%h bad=%b exp ce1=1 ce2=1 bank=00 bad=0",
               xce1_n, xce2_n, bank_pins, cfg_bad);
    end
    @(posedge clk); #1;
    // R1: select 3 writes nothing; the per-cycle compare observes the pins
    cfg_write(2'd3, 7'h7F);
    bus(16'h4100, 1, 0, 0);
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 2; d++)
        for (int ai = 0; ai < 4; ai++)
          for (int bi = 0; bi < 2; bi++) begin
            rom_int_off = d[0];
            cfg_write(2'd0, {2'b11, avals[ai]});
            cfg_write(2'd1, bvals[bi]);
            cfg_write(2'd2, 7'(m));
            for (int k = 0; k < 7; k++)
              for (int j = 0; j < 8; j++)
                bus(addrs[k], !j[2], j[0], j[1]);
          end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule